// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects up to 128 interrupt sources and presents the CPU with a single request line, together with the vector and priority of the source that should be serviced next. Each source carries a 4-bit priority that software writes. A priority of zero disables the source. The lowest-numbered sources are raised and cleared only by software strobes. All other sources follow their request wires level for level.

Among the pending, enabled sources the one with the highest priority wins. When several share that priority, the lowest source number wins. The request line rises only when the winner's priority is strictly above the current priority mask. Software may write the mask at any time, for example to hold off every task that shares a resource (priority ceiling).

Acknowledging the request saves the old mask on a hardware stack and raises the mask to the serviced priority, so only higher levels can then preempt. End-of-interrupt restores the saved mask. Nested service therefore needs no software bookkeeping of mask values.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous active-low reset, all priorities are 0, all software pending bits are clear, the mask is 0, the stack is empty and `irq` is low.
- R2: A source whose priority is 0 never wins and never raises `irq`, even while it is pending.
- R3: `irq_vec` carries the number of the winning pending source, zero-extended to 9 bits. The winner is the enabled pending source with the highest priority, and `irq_prio` shows its priority. With no candidate, both read 0. A priority write takes effect from the cycle after the write strobe.
- R4: When pending sources tie on the highest priority, the one with the lowest source number wins.
- R5: `irq` is high exactly when the winner's priority is strictly greater than `cur_mask`. A `mask_we` strobe loads `mask_val` into the mask in the next cycle.
- R6: Sources 0 to 7 are software sources. Bit i of `sw_set` makes source i pending from the next cycle, and it stays pending until bit i of `sw_clr` is strobed. If both strobes fall in the same cycle, set wins.
- R7: Source n (8 to 127) is pending exactly while `hw_src[n-8]` is high, with no register delay between the input and the outputs.
- R8: An `ack` while `irq` is high pushes the current mask onto the stack and loads the mask with `irq_prio` in the next cycle. An `ack` while `irq` is low changes nothing.
- R9: An `eoi` pops the stack into the mask in the next cycle. An `eoi` with an empty stack changes nothing.
- R10: The stack holds 16 entries and returns them last-in first-out. An `ack` with a full stack changes nothing.
- R11: When strobes coincide, an effective `ack` takes precedence over `eoi`, and an effective `eoi` takes precedence over `mask_we`. A strobe that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_src | input | 120 | Level requests of sources 8..127 (bit j is source j+8) |
| sw_set | input | 8 | Set strobes of software sources 0..7 |
| sw_clr | input | 8 | Clear strobes of software sources 0..7 |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | 7 | Source number to write |
| prio_val | input | 4 | Priority to write (0 disables) |
| mask_we | input | 1 | Mask write strobe |
| mask_val | input | 4 | Mask value to write |
| ack | input | 1 | CPU acknowledge of the current request |
| eoi | input | 1 | End of interrupt service |
| irq | output | 1 | Request to the CPU |
| irq_vec | output | 9 | Vector of the winning source |
| irq_prio | output | 4 | Priority of the winning source |
| cur_mask | output | 4 | Current priority mask |

## Verification
Assertions check four things on every cycle: a raised request always points at a source that is pending with the reported priority; no lower-numbered neighbour with equal or higher priority is overlooked; an effective acknowledge lands the serviced priority in the mask; and pushes, pops, software pending bits and priority writes update their state as intended. Some behaviour needs sequences of stimulus, so only the bench scenarios can show it. These are the last-in first-out order across a full stack, the dropping of an acknowledge at full depth and of a pop from an empty stack, strobe precedence in one cycle, and preemption by a newly enabled higher level. The bench compares every output against its behavioural model on every clock.

// File: rtl/intc_pkg.sv
// Shared types of the priority interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package intc_pkg;

    // Mask update selected for one cycle
    typedef enum logic [1:0] {
        MOP_HOLD  = 2'd0,
        MOP_PUSH  = 2'd1,
        MOP_POP   = 2'd2,
        MOP_WRITE = 2'd3
    } mask_op_e;

endpackage

// File: rtl/intc_src_regs.sv
// Per-source priority registers and software pending flags.
// Produces the pending vector: the low NUM_SW entries come from software
// flags, the rest follow the level inputs directly.
// Assumes: NUM_SRC > NUM_SW, strobes are single-cycle pulses from the bus side.
module intc_src_regs #(
    parameter int NUM_SRC = 128,
    parameter int NUM_SW  = 8,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-NUM_SW-1:0]        hw_src,
    input  logic [NUM_SW-1:0]                sw_set,
    input  logic [NUM_SW-1:0]                sw_clr,
    input  logic                             prio_we,
    input  logic [IDX_W-1:0]                 prio_idx,
    input  logic [PRIO_W-1:0]                prio_val,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q,
    output logic [NUM_SRC-1:0]               pend
);

    logic [NUM_SW-1:0] sw_q;

    // Priority table: one write port, cleared to disabled on reset
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q           <= '0;
        else if (prio_we) prio_q[prio_idx] <= prio_val;
    end

    // Software pending flags: set dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_set | (sw_q & ~sw_clr);
    end

    // Pending vector: software flags below, level inputs above
    always_comb pend = {hw_src, sw_q};

    p_sw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set == '0 && sw_clr == '0) |=> $stable(sw_q));

    p_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set != '0) |=> ((sw_q & $past(sw_set)) == $past(sw_set)));

    p_prio_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prio_we |=> (prio_q[$past(prio_idx)] == $past(prio_val)));

endmodule

// File: rtl/intc_arb.sv
// Combinational arbiter: a balanced binary tree that keeps the highest
// priority. On a tie the left branch, which holds the lower source number,
// wins. A non-pending source enters the tree as priority 0.
// Assumes: N is a power of two and at least 2.
module intc_arb #(
    parameter int N      = 128,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0][PRIO_W-1:0] prio,
    input  logic [N-1:0]             pend,
    output logic [PRIO_W-1:0]        win_prio,
    output logic [IDX_W-1:0]         win_idx
);

    localparam int NODES = 2 * N;

    logic [PRIO_W-1:0] np [1:NODES-1];
    logic [IDX_W-1:0]  ni [1:NODES-1];

    // Leaves sit at N..2N-1; a source that is not pending is forced to 0
    for (genvar k = 0; k < N; k++) begin : g_leaf
        assign np[N+k] = pend[k] ? prio[k] : '0;
        assign ni[N+k] = IDX_W'(k);
    end

    // Inner node k merges 2k and 2k+1; the right child wins only when strictly higher
    for (genvar k = 1; k < N; k++) begin : g_node
        assign np[k] = (np[2*k+1] > np[2*k]) ? np[2*k+1] : np[2*k];
        assign ni[k] = (np[2*k+1] > np[2*k]) ? ni[2*k+1] : ni[2*k];
    end

    assign win_prio = np[1];
    assign win_idx  = ni[1];

endmodule

// File: rtl/intc_mask_stack.sv
// Current priority mask and its save stack. A push saves the mask and loads
// a new level, a pop restores the last saved level, and a write loads a new
// level without touching the stack.
// Assumes: the caller never requests a push when full or a pop when empty.
// Stack data cells are not reset; only the count is.
module intc_mask_stack #(
    parameter int PRIO_W    = 4,
    parameter int STK_DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  intc_pkg::mask_op_e     op,
    input  logic [PRIO_W-1:0]      push_val,
    input  logic [PRIO_W-1:0]      wr_val,
    output logic [PRIO_W-1:0]      mask_q,
    output logic                   full,
    output logic                   empty
);
    import intc_pkg::*;

    localparam int CNT_W = $clog2(STK_DEPTH + 1);
    localparam int PTR_W = $clog2(STK_DEPTH);

    logic [PRIO_W-1:0] stk [STK_DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  top_ptr;

    // Free slot and last saved slot
    always_comb begin
        wr_ptr  = cnt[PTR_W-1:0];
        top_ptr = PTR_W'(cnt - CNT_W'(1));
    end

    assign full  = (cnt == CNT_W'(STK_DEPTH));
    assign empty = (cnt == '0);

    // Mask and depth update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cnt    <= '0;
        end else begin
            case (op)
                MOP_PUSH: begin
                    mask_q <= push_val;
                    cnt    <= cnt + CNT_W'(1);
                end
                MOP_POP: begin
                    mask_q <= stk[top_ptr];
                    cnt    <= cnt - CNT_W'(1);
                end
                MOP_WRITE: mask_q <= wr_val;
                default:   ;
            endcase
        end
    end

    // Save slot written on a push
    always_ff @(posedge clk) begin
        if (op == MOP_PUSH) stk[wr_ptr] <= mask_q;
    end

    p_push_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_PUSH) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_pop_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MOP_POP) |=> (mask_q == $past(stk[top_ptr]) && cnt == $past(cnt) - CNT_W'(1)));

    p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(STK_DEPTH));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (op != MOP_PUSH));

endmodule

// File: rtl/prio_intc.sv
// Preemptive priority interrupt controller (top).
// Picks the highest-priority pending source (lowest number on ties), raises
// irq when that level is above the mask, and manages the mask on ack/eoi
// through a hardware stack.
// Assumes: all strobes are synchronous to clk. Sources 0..NUM_SW-1 are
// software-only; hw_src bit j drives source j+NUM_SW.
module prio_intc #(
    parameter int NUM_SRC   = 128,
    parameter int NUM_SW    = 8,
    parameter int PRIO_W    = 4,
    parameter int STK_DEPTH = 16,
    parameter int VEC_W     = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-NUM_SW-1:0]   hw_src,
    input  logic [NUM_SW-1:0]           sw_set,
    input  logic [NUM_SW-1:0]           sw_clr,
    input  logic                        prio_we,
    input  logic [$clog2(NUM_SRC)-1:0]  prio_idx,
    input  logic [PRIO_W-1:0]           prio_val,
    input  logic                        mask_we,
    input  logic [PRIO_W-1:0]           mask_val,
    input  logic                        ack,
    input  logic                        eoi,
    output logic                        irq,
    output logic [VEC_W-1:0]            irq_vec,
    output logic [PRIO_W-1:0]           irq_prio,
    output logic [PRIO_W-1:0]           cur_mask
);
    import intc_pkg::*;

    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_SRC-1:0]             pend;
    logic [PRIO_W-1:0]              win_prio;
    logic [IDX_W-1:0]               win_idx;
    logic                           stk_full;
    logic                           stk_empty;
    logic                           do_ack;
    logic                           do_eoi;
    mask_op_e                       op;

    intc_src_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_SW  (NUM_SW),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_src   (hw_src),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr),
        .prio_we  (prio_we),
        .prio_idx (prio_idx),
        .prio_val (prio_val),
        .prio_q   (prio_q),
        .pend     (pend)
    );

    intc_arb #(
        .N      (NUM_SRC),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_arb (
        .prio     (prio_q),
        .pend     (pend),
        .win_prio (win_prio),
        .win_idx  (win_idx)
    );

    // Request gate: the winner must be strictly above the mask
    always_comb begin
        irq      = (win_prio > cur_mask);
        irq_vec  = VEC_W'(win_idx);
        irq_prio = win_prio;
    end

    // Strobe precedence: effective ack, then effective eoi, then mask write
    always_comb begin
        do_ack = ack && irq && !stk_full;
        do_eoi = eoi && !do_ack && !stk_empty;
        if (do_ack)       op = MOP_PUSH;
        else if (do_eoi)  op = MOP_POP;
        else if (mask_we) op = MOP_WRITE;
        else              op = MOP_HOLD;
    end

    intc_mask_stack #(
        .PRIO_W    (PRIO_W),
        .STK_DEPTH (STK_DEPTH)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .push_val (win_prio),
        .wr_val   (mask_val),
        .mask_q   (cur_mask),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    p_irq_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend[win_idx] && prio_q[win_idx] == irq_prio));

    p_tie_low_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && win_idx != '0) |->
            !(pend[win_idx - IDX_W'(1)] && prio_q[win_idx - IDX_W'(1)] >= irq_prio));

    p_ack_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !stk_full) |=> (cur_mask == $past(irq_prio)));

    p_disabled_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_prio != '0));

endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;

    localparam int NSRC = 128;
    localparam int NSW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-NSW-1:0] hw_src = '0;
    logic [NSW-1:0]    sw_set = '0;
    logic [NSW-1:0]    sw_clr = '0;
    logic              prio_we = 1'b0;
    logic [6:0]        prio_idx = '0;
    logic [3:0]        prio_val = '0;
    logic              mask_we = 1'b0;
    logic [3:0]        mask_val = '0;
    logic              ack = 1'b0;
    logic              eoi = 1'b0;
    logic              irq;
    logic [8:0]        irq_vec;
    logic [3:0]        irq_prio;
    logic [3:0]        cur_mask;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .hw_src(hw_src), .sw_set(sw_set), .sw_clr(sw_clr),
        .prio_we(prio_we), .prio_idx(prio_idx), .prio_val(prio_val),
        .mask_we(mask_we), .mask_val(mask_val), .ack(ack), .eoi(eoi),
        .irq(irq), .irq_vec(irq_vec), .irq_prio(irq_prio), .cur_mask(cur_mask)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_prio [NSRC];
    bit m_sw   [NSW];
    int m_mask;
    int m_stk[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_pend(input int s);
        if (s < NSW) return m_sw[s];
        return hw_src[s-NSW];
    endfunction

    // Winner search: scan upward, replace only on strictly higher level
    function automatic void m_win(output int best, output int idx);
        best = 0; idx = 0;
        for (int s = 0; s < NSRC; s++)
            if (m_pend(s) && m_prio[s] > best) begin
                best = m_prio[s];
                idx  = s;
            end
    endfunction

    // Model update on each rising edge
    always @(posedge clk) begin
        int best, idx;
        bit a, e;
        if (!rst_n) begin
            for (int s = 0; s < NSRC; s++) m_prio[s] = 0;
            for (int s = 0; s < NSW; s++)  m_sw[s] = 1'b0;
            m_mask = 0;
            m_stk.delete();
        end else begin
            m_win(best, idx);
            a = ack && (best > m_mask) && (m_stk.size() < 16);
            e = eoi && !a && (m_stk.size() > 0);
            if (a) begin
                m_stk.push_back(m_mask);
                m_mask = best;
            end else if (e) begin
                m_mask = m_stk.pop_back();
            end else if (mask_we) begin
                m_mask = int'(mask_val);
            end
            for (int s = 0; s < NSW; s++)
                if (sw_set[s]) m_sw[s] = 1'b1;
                else if (sw_clr[s]) m_sw[s] = 1'b0;
            if (prio_we) m_prio[prio_idx] = int'(prio_val);
        end
    end

    // Per-cycle comparison, 1 ns after the falling edge
    always @(negedge clk) begin
        int best, idx;
        #1;
        if (cmp_en) begin
            m_win(best, idx);
            chk(irq == (best > m_mask), cur_req, "irq", int'(irq), int'(best > m_mask));
            chk(int'(irq_vec) == idx, cur_req, "irq_vec", int'(irq_vec), idx);
            chk(int'(irq_prio) == best, cur_req, "irq_prio", int'(irq_prio), best);
            chk(int'(cur_mask) == m_mask, cur_req, "cur_mask", int'(cur_mask), m_mask);
        end
    end

    // Next cycle with all strobes cleared
    task automatic cyc();
        @(negedge clk);
        ack = 0; eoi = 0; mask_we = 0; prio_we = 0; sw_set = '0; sw_clr = '0;
    endtask

    task automatic set_hw(input int s, input bit v);
        hw_src[s-NSW] = v;
    endtask

    task automatic wprio(input int s, input int p);
        prio_we = 1; prio_idx = 7'(s); prio_val = 4'(p);
    endtask

    task automatic wmask(input int v);
        mask_we = 1; mask_val = 4'(v);
    endtask

    // Directed expectation, vector check skipped when e_vec < 0
    task automatic expect_out(input string req, input bit e_irq, input int e_vec, input int e_mask);
        #1.5;
        chk(irq == e_irq, req, "irq", int'(irq), int'(e_irq));
        if (e_vec >= 0) chk(int'(irq_vec) == e_vec, req, "irq_vec", int'(irq_vec), e_vec);
        chk(int'(cur_mask) == e_mask, req, "cur_mask", int'(cur_mask), e_mask);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_en = 1;
        cur_req = "R1";
        expect_out("R1", 0, 0, 0);

        cur_req = "R2";
        cyc(); set_hw(20, 1); expect_out("R2", 0, 0, 0);
        cyc(); wprio(20, 5);  expect_out("R2", 0, 0, 0);
        cur_req = "R3";
        cyc(); expect_out("R3", 1, 20, 0);
        cyc(); wprio(30, 9); set_hw(30, 1);
        cyc(); expect_out("R3", 1, 30, 0);

        cur_req = "R4";
        cyc(); wprio(10, 9); set_hw(10, 1);
        cyc(); expect_out("R4", 1, 10, 0);

        cur_req = "R7";
        cyc(); set_hw(10, 0); expect_out("R7", 1, 30, 0);

        cur_req = "R5";
        cyc(); wmask(9);
        cyc(); expect_out("R5", 0, 30, 9);
        cyc(); wmask(8);
        cyc(); expect_out("R5", 1, 30, 8);

        cur_req = "R6";
        cyc(); wprio(3, 12);
        cyc(); sw_set = 8'h08; expect_out("R6", 1, 30, 8);
        cyc(); expect_out("R6", 1, 3, 8);
        cyc(); expect_out("R6", 1, 3, 8);
        cyc(); sw_clr = 8'h08;
        cyc(); expect_out("R6", 1, 30, 8);
        cyc(); sw_set = 8'h08; sw_clr = 8'h08;
        cyc(); expect_out("R6", 1, 3, 8);

        cur_req = "R8";
        cyc(); ack = 1;
        cyc(); expect_out("R8", 0, 3, 12);
        cyc(); wprio(40, 14); set_hw(40, 1);
        cyc(); expect_out("R8", 1, 40, 12);
        cyc(); ack = 1;
        cyc(); expect_out("R8", 0, 40, 14);
        cyc(); ack = 1;
        cyc(); expect_out("R8", 0, 40, 14);

        cur_req = "R9";
        cyc(); eoi = 1;
        cyc(); expect_out("R9", 1, 40, 12);
        cyc(); eoi = 1;
        cyc(); expect_out("R9", 1, 40, 8);
        cyc(); eoi = 1;
        cyc(); expect_out("R9", 1, 40, 8);
        cyc(); sw_clr = 8'h08; set_hw(40, 0); set_hw(30, 0); set_hw(20, 0);
        cyc(); expect_out("R9", 0, 0, 8);

        cur_req = "R11";
        cyc(); set_hw(30, 1);
        cyc(); ack = 1; eoi = 1; wmask(2);
        cyc(); expect_out("R11", 0, 30, 9);
        cyc(); eoi = 1; wmask(5);
        cyc(); expect_out("R11", 1, 30, 8);
        cyc(); wmask(5);
        cyc(); expect_out("R11", 1, 30, 5);
        set_hw(30, 0);

        cur_req = "R10";
        cyc(); wprio(50, 15); set_hw(50, 1);
        for (int i = 0; i < 16; i++) begin
            cyc(); wmask(i % 15);
            cyc(); ack = 1;
            cyc(); expect_out("R10", 0, 50, 15);
        end
        cyc(); wmask(3);
        cyc(); ack = 1;
        cyc(); expect_out("R10", 1, 50, 3);
        for (int k = 15; k >= 0; k--) begin
            cyc(); eoi = 1;
            cyc(); expect_out("R10", (k % 15) < 15, 50, k % 15);
        end
        cyc(); eoi = 1;
        cyc(); expect_out("R9", 1, 50, 0);

        cyc(); cyc();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule